// File: doc/BRIEF.md
# DMA Strobe Cycle Timer

This block paces word transfers between a host and a disk drive during multiword or single-word DMA. At the start of a transfer it works out how long each word cycle must last. The slow modes use a fixed minimum. The two fastest multiword modes use a shorter minimum, which is raised to the drive's own reported cycle time whenever the drive asks for more. The block then picks one of four fixed timing types, the fastest one whose full cycle is long enough. It also reports the peak rate that the chosen cycle allows.

Once running, it drives a strobe through alternating active and recovery phases. Each phase lasts a whole number of clock ticks, and each active phase moves one word. A new word cycle begins only while the drive's request line is high. When the word count runs out, or when an abort is seen, the block stops. It then raises done and flags whether any words were left untransferred. All settings are latched at start, so the mode and the drive time can change freely while a transfer is in flight.

Top module: `dma_strobe_timer`

## Requirements
- R1: A mode code of 5 or 6 gives a 250 ns cycle, raised to drive_cycle_ns when that is larger. Every other code gives 480 ns and ignores drive_cycle_ns. The chosen value appears on cycle_ns from the cycle after start is accepted.
- R2: timing_type is the fastest type whose total cycle is at least cycle_ns. The encoding is 0=A (562 ns), 1=B (437 ns), 2=C (250 ns), 3=D (187 ns). Type A is used when no type is long enough.
- R3: peak_mbps equals 2000 divided by cycle_ns, rounded down.
- R4: Each strobe active phase and recovery phase lasts a fixed number of clock cycles, written active/recovery: A 4/5, B 3/4, C 2/2, D 1/2.
- R5: A word cycle (strobe rising) begins only after a clock edge at which dreq was high. While dreq stays low between words, the strobe stays low and words_left holds.
- R6: words_left loads word_count at start and drops by one at the end of each active phase. After the last recovery phase busy falls, done rises, the strobe stays low and residue_nz is 0.
- R7: A start with word_count of 0 raises done one cycle later, with no strobe pulse and residue_nz at 0.
- R8: An abort during an active or recovery phase ends the transfer after the current recovery phase. An abort while waiting for dreq ends it at the next edge. In both cases residue_nz is 1 if words_left is nonzero.
- R9: A start while busy is ignored, and so is an abort while idle. Latched settings and outputs do not change.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| xfer_mode | input | 3 | Transfer mode code (see R1) |
| drive_cycle_ns | input | 16 | Minimum cycle reported by the drive, ns |
| word_count | input | 8 | Number of words to move |
| dreq | input | 1 | Drive request line |
| abort | input | 1 | Stop after the current recovery phase |
| strobe | output | 1 | Read/write strobe, high in active phase |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished; held until the next start |
| residue_nz | output | 1 | Finished with words remaining |
| words_left | output | 8 | Words still to transfer |
| timing_type | output | 2 | Chosen timing type (see R2) |
| cycle_ns | output | 16 | Chosen cycle time, ns |
| peak_mbps | output | 5 | Peak rate, MB/s |

## Verification
The hardest case to reach is an abort arriving in the final cycle of a recovery phase. A close second is dreq dropping in exactly the cycle where recovery would hand straight over to the next active phase. Both depend on where an edge falls inside a phase a few ticks long. Directed tests reach only a few of these points. The stimulus therefore runs many transfers with a random mode, drive time, count, a per-cycle random dreq and an abort at a random offset. A behavioural model follows every clock, so each landing point that occurs gets checked.

// File: rtl/dst_pkg.sv
package dst_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_MW1 = 3'd5;
   localparam logic [MODE_W-1:0] MODE_MW2 = 3'd6;

   typedef enum logic [1:0] {
      TT_A = 2'd0,
      TT_B = 2'd1,
      TT_C = 2'd2,
      TT_D = 2'd3
   } tt_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_ACT  = 2'd2,
      PH_REC  = 2'd3
   } ph_e;
endpackage

// File: rtl/dst_cycle_select.sv
module dst_cycle_select
   import dst_pkg::*;
#(
   parameter int TIME_W   = 16,
   parameter int FAST_NS  = 250,
   parameter int SLOW_NS  = 480,
   parameter int CYC_B_NS = 437,
   parameter int CYC_C_NS = 250,
   parameter int CYC_D_NS = 187
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [TIME_W-1:0] drive_ns,
   output logic [TIME_W-1:0] cyc_ns,
   output tt_e               ttype
);
   localparam logic [TIME_W-1:0] FAST_V = TIME_W'(FAST_NS);
   localparam logic [TIME_W-1:0] SLOW_V = TIME_W'(SLOW_NS);

   logic fast_mode;

   always_comb begin
      fast_mode = (mode == MODE_MW1) || (mode == MODE_MW2);
      if (fast_mode)
         cyc_ns = (drive_ns > FAST_V) ? drive_ns : FAST_V;
      else
         cyc_ns = SLOW_V;
   end

   always_comb begin
      if (int'(cyc_ns) <= CYC_D_NS)      ttype = TT_D;
      else if (int'(cyc_ns) <= CYC_C_NS) ttype = TT_C;
      else if (int'(cyc_ns) <= CYC_B_NS) ttype = TT_B;
      else                               ttype = TT_A;
   end
endmodule

// File: rtl/dst_peak_calc.sv
module dst_peak_calc #(
   parameter int TIME_W   = 16,
   parameter int PEAK_NUM = 2000,
   parameter int PEAK_MAX = 16,
   parameter int PEAK_W   = $clog2(PEAK_MAX + 1)
) (
   input  logic [TIME_W-1:0] cyc_ns,
   output logic [PEAK_W-1:0] peak
);
   logic [PEAK_MAX-1:0] fits;

   for (genvar k = 0; k < PEAK_MAX; k++) begin : g_fit
      assign fits[k] = ((k + 1) * int'(cyc_ns)) <= PEAK_NUM;
   end

   always_comb begin
      peak = '0;
      for (int i = 0; i < PEAK_MAX; i++)
         peak = peak + PEAK_W'(fits[i]);
   end
endmodule

// File: rtl/dst_phase_seq.sv
module dst_phase_seq
   import dst_pkg::*;
#(
   parameter int COUNT_W = 8,
   parameter int TICK_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COUNT_W-1:0] word_count,
   input  logic               dreq,
   input  logic               abort,
   input  logic [TICK_W-1:0]  act_len,
   input  logic [TICK_W-1:0]  rec_len,
   output logic               strobe,
   output logic               busy,
   output logic               done,
   output logic               residue_nz,
   output logic [COUNT_W-1:0] words_left
);
   localparam logic [TICK_W-1:0]  TICK_ONE  = TICK_W'(1);
   localparam logic [COUNT_W-1:0] COUNT_ONE = COUNT_W'(1);

   ph_e                ph_q;
   logic [TICK_W-1:0]  tick_q;
   logic [COUNT_W-1:0] left_q;
   logic               stop_pend_q;
   logic               done_q;
   logic               res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         tick_q      <= '0;
         left_q      <= '0;
         stop_pend_q <= 1'b0;
         done_q      <= 1'b0;
         res_q       <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  left_q      <= word_count;
                  stop_pend_q <= 1'b0;
                  res_q       <= 1'b0;
                  if (word_count == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     done_q <= 1'b0;
                     ph_q   <= PH_WAIT;
                  end
               end
            end
            PH_WAIT: begin
               if (abort) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
                  res_q  <= (left_q != '0);
               end else if (dreq) begin
                  ph_q   <= PH_ACT;
                  tick_q <= act_len - TICK_ONE;
               end
            end
            PH_ACT: begin
               if (abort) stop_pend_q <= 1'b1;
               if (tick_q == '0) begin
                  ph_q   <= PH_REC;
                  tick_q <= rec_len - TICK_ONE;
                  left_q <= left_q - COUNT_ONE;
               end else begin
                  tick_q <= tick_q - TICK_ONE;
               end
            end
            PH_REC: begin
               if (tick_q == '0) begin
                  if (left_q == '0 || stop_pend_q || abort) begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b1;
                     res_q  <= (left_q != '0);
                  end else if (dreq) begin
                     ph_q   <= PH_ACT;
                     tick_q <= act_len - TICK_ONE;
                  end else begin
                     ph_q   <= PH_WAIT;
                  end
               end else begin
                  tick_q <= tick_q - TICK_ONE;
                  if (abort) stop_pend_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign strobe     = (ph_q == PH_ACT);
   assign busy       = (ph_q != PH_IDLE);
   assign done       = done_q;
   assign residue_nz = res_q;
   assign words_left = left_q;

   logic [TICK_W:0] hi_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_run_q <= '0;
      else if (strobe) hi_run_q <= hi_run_q + 1'b1;
      else             hi_run_q <= '0;
   end

   AST_ACTIVE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> hi_run_q == {1'b0, act_len});   // R4
   AST_DREQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(dreq));   // R5
   AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> (words_left == $past(words_left)) ||
         ((words_left == $past(words_left) - COUNT_ONE) && $fell(strobe)));   // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !strobe);   // R6
   AST_RES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      residue_nz |-> done && (words_left != '0));   // R8
endmodule

// File: rtl/dma_strobe_timer.sv
module dma_strobe_timer
   import dst_pkg::*;
#(
   parameter int COUNT_W  = 8,
   parameter int TIME_W   = 16,
   parameter int TICK_W   = 4,
   parameter int FAST_NS  = 250,
   parameter int SLOW_NS  = 480,
   parameter int CYC_A_NS = 562,
   parameter int CYC_B_NS = 437,
   parameter int CYC_C_NS = 250,
   parameter int CYC_D_NS = 187,
   parameter int ACT_A = 4, parameter int REC_A = 5,
   parameter int ACT_B = 3, parameter int REC_B = 4,
   parameter int ACT_C = 2, parameter int REC_C = 2,
   parameter int ACT_D = 1, parameter int REC_D = 2,
   parameter int PEAK_NUM = 2000,
   parameter int PEAK_MAX = 16,
   parameter int PEAK_W   = $clog2(PEAK_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         xfer_mode,
   input  logic [TIME_W-1:0]  drive_cycle_ns,
   input  logic [COUNT_W-1:0] word_count,
   input  logic               dreq,
   input  logic               abort,
   output logic               strobe,
   output logic               busy,
   output logic               done,
   output logic               residue_nz,
   output logic [COUNT_W-1:0] words_left,
   output logic [1:0]         timing_type,
   output logic [TIME_W-1:0]  cycle_ns,
   output logic [PEAK_W-1:0]  peak_mbps
);
   localparam int ACT_TAB[4] = '{ACT_A, ACT_B, ACT_C, ACT_D};
   localparam int REC_TAB[4] = '{REC_A, REC_B, REC_C, REC_D};
   localparam int TOT_TAB[4] = '{CYC_A_NS, CYC_B_NS, CYC_C_NS, CYC_D_NS};
   localparam int TICK_LIM   = 2 ** TICK_W;

   if (ACT_A < 1 || ACT_B < 1 || ACT_C < 1 || ACT_D < 1 ||
       REC_A < 1 || REC_B < 1 || REC_C < 1 || REC_D < 1) begin : g_bad_min
      $error("every phase needs at least one tick");
   end
   if (ACT_A > TICK_LIM || ACT_B > TICK_LIM || ACT_C > TICK_LIM || ACT_D > TICK_LIM ||
       REC_A > TICK_LIM || REC_B > TICK_LIM || REC_C > TICK_LIM || REC_D > TICK_LIM) begin : g_bad_max
      $error("phase length does not fit TICK_W");
   end
   if (!(CYC_D_NS < CYC_C_NS && CYC_C_NS < CYC_B_NS && CYC_B_NS < CYC_A_NS)) begin : g_bad_order
      $error("type cycle totals must rise from D to A");
   end
   if (FAST_NS < 1 || PEAK_NUM / FAST_NS > PEAK_MAX) begin : g_bad_peak
      $error("PEAK_MAX too small for the fastest cycle");
   end
   if (SLOW_NS >= 2 ** TIME_W || CYC_A_NS >= 2 ** TIME_W) begin : g_bad_time
      $error("TIME_W too narrow");
   end

   logic [TIME_W-1:0] sel_cyc;
   tt_e               sel_type;
   logic [PEAK_W-1:0] sel_peak;

   dst_cycle_select #(
      .TIME_W(TIME_W), .FAST_NS(FAST_NS), .SLOW_NS(SLOW_NS),
      .CYC_B_NS(CYC_B_NS), .CYC_C_NS(CYC_C_NS), .CYC_D_NS(CYC_D_NS)
   ) u_sel (
      .mode     (xfer_mode),
      .drive_ns (drive_cycle_ns),
      .cyc_ns   (sel_cyc),
      .ttype    (sel_type)
   );

   dst_peak_calc #(
      .TIME_W(TIME_W), .PEAK_NUM(PEAK_NUM), .PEAK_MAX(PEAK_MAX), .PEAK_W(PEAK_W)
   ) u_peak (
      .cyc_ns (sel_cyc),
      .peak   (sel_peak)
   );

   tt_e               type_r;
   logic [TIME_W-1:0] cyc_r;
   logic [PEAK_W-1:0] peak_r;
   logic              seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_r <= TT_A;
         cyc_r  <= '0;
         peak_r <= '0;
      end else if (start && !seq_busy) begin
         type_r <= sel_type;
         cyc_r  <= sel_cyc;
         peak_r <= sel_peak;
      end
   end

   logic [TICK_W-1:0] act_len;
   logic [TICK_W-1:0] rec_len;
   always_comb begin
      act_len = TICK_W'(ACT_TAB[int'(type_r)]);
      rec_len = TICK_W'(REC_TAB[int'(type_r)]);
   end

   dst_phase_seq #(
      .COUNT_W(COUNT_W), .TICK_W(TICK_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .word_count (word_count),
      .dreq       (dreq),
      .abort      (abort),
      .act_len    (act_len),
      .rec_len    (rec_len),
      .strobe     (strobe),
      .busy       (seq_busy),
      .done       (done),
      .residue_nz (residue_nz),
      .words_left (words_left)
   );

   assign busy        = seq_busy;
   assign timing_type = type_r;
   assign cycle_ns    = cyc_r;
   assign peak_mbps   = peak_r;

   AST_TYPE_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (type_r == TT_A) || (TOT_TAB[int'(type_r)] >= int'(cyc_r)));   // R2
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(type_r) && $stable(cyc_r));   // R9
   AST_CYC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> int'(cyc_r) >= FAST_NS);   // R1
endmodule

// File: tb/sim_dma_strobe_timer.sv
module sim_dma_strobe_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  xfer_mode = '0;
   logic [15:0] drive_cycle_ns = '0;
   logic [7:0]  word_count = '0;
   logic        dreq = 1'b0;
   logic        abort = 1'b0;
   logic        strobe, busy, done, residue_nz;
   logic [7:0]  words_left;
   logic [1:0]  timing_type;
   logic [15:0] cycle_ns;
   logic [4:0]  peak_mbps;

   always #4 clk = ~clk;

   dma_strobe_timer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_mode(xfer_mode),
      .drive_cycle_ns(drive_cycle_ns), .word_count(word_count), .dreq(dreq),
      .abort(abort), .strobe(strobe), .busy(busy), .done(done),
      .residue_nz(residue_nz), .words_left(words_left), .timing_type(timing_type),
      .cycle_ns(cycle_ns), .peak_mbps(peak_mbps)
   );

   int total = 0;
   int failed = 0;
   int hi_cnt = 0;
   int cycles = 0;
   bit dreq_rand = 0;

   int act_tab[4] = '{4, 3, 2, 1};
   int rec_tab[4] = '{5, 4, 2, 2};

   // behavioural reference: phase 0 idle, 1 wait, 2 active, 3 recovery
   int m_ph = 0, m_t = 0, m_left = 0, m_type = 0, m_cyc = 0, m_peak = 0;
   bit m_done = 0, m_res = 0, m_stop = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_t = 0; m_left = 0; m_type = 0; m_cyc = 0; m_peak = 0;
         m_done = 0; m_res = 0; m_stop = 0;
      end else begin
         case (m_ph)
            0: if (start) begin
               if (xfer_mode == 5 || xfer_mode == 6)
                  m_cyc = (drive_cycle_ns > 250) ? int'(drive_cycle_ns) : 250;
               else
                  m_cyc = 480;
               m_type = (m_cyc <= 187) ? 3 : (m_cyc <= 250) ? 2 : (m_cyc <= 437) ? 1 : 0;
               m_peak = 2000 / m_cyc;
               m_left = word_count; m_res = 0; m_stop = 0;
               if (word_count == 0) m_done = 1;
               else begin m_done = 0; m_ph = 1; end
            end
            1: if (abort) begin
               m_ph = 0; m_done = 1; m_res = (m_left != 0);
            end else if (dreq) begin
               m_ph = 2; m_t = act_tab[m_type] - 1;
            end
            2: begin
               if (abort) m_stop = 1;
               if (m_t == 0) begin m_ph = 3; m_t = rec_tab[m_type] - 1; m_left--; end
               else m_t--;
            end
            default: begin
               if (m_t == 0) begin
                  if (m_left == 0 || m_stop || abort) begin
                     m_ph = 0; m_done = 1; m_res = (m_left != 0);
                  end else if (dreq) begin
                     m_ph = 2; m_t = act_tab[m_type] - 1;
                  end else m_ph = 1;
               end else begin
                  m_t--;
                  if (abort) m_stop = 1;
               end
            end
         endcase
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (strobe !== (m_ph == 2) || busy !== (m_ph != 0) || done !== m_done ||
             residue_nz !== m_res || int'(words_left) != m_left ||
             int'(timing_type) != m_type || int'(cycle_ns) != m_cyc ||
             int'(peak_mbps) != m_peak) begin
            failed++;
            if (strobe !== (m_ph == 2)) $display("FAIL R4/R5 strobe: actual %0b expected %0b", strobe, m_ph == 2);
            if (busy !== (m_ph != 0)) $display("FAIL R6 busy: actual %0b expected %0b", busy, m_ph != 0);
            if (done !== m_done) $display("FAIL R6 done: actual %0b expected %0b", done, m_done);
            if (residue_nz !== m_res) $display("FAIL R8 residue: actual %0b expected %0b", residue_nz, m_res);
            if (int'(words_left) != m_left) $display("FAIL R6 words_left: actual %0d expected %0d", words_left, m_left);
            if (int'(timing_type) != m_type) $display("FAIL R2 type: actual %0d expected %0d", timing_type, m_type);
            if (int'(cycle_ns) != m_cyc) $display("FAIL R1 cycle: actual %0d expected %0d", cycle_ns, m_cyc);
            if (int'(peak_mbps) != m_peak) $display("FAIL R3 peak: actual %0d expected %0d", peak_mbps, m_peak);
         end
         if (strobe) hi_cnt++;
         if (dreq_rand) dreq = ($urandom % 4) != 0;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failed++; total++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   task automatic go(input int mode, input int drv, input int cnt);
      @(negedge clk);
      hi_cnt = 0;
      xfer_mode = 3'(mode); drive_cycle_ns = 16'(drv); word_count = 8'(cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
   endtask

   task automatic check_cfg(input int cyc, input int ty, input int pk, input string tag);
      chk(int'(cycle_ns) == cyc, {tag, " cycle_ns"}, cycle_ns, cyc);
      chk(int'(timing_type) == ty, {tag, " timing_type"}, timing_type, ty);
      chk(int'(peak_mbps) == pk, {tag, " peak_mbps"}, peak_mbps, pk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!strobe && !busy && !done && !residue_nz, "R10 flags", {strobe, busy, done, residue_nz}, 0);
      chk(words_left == 0 && timing_type == 0 && cycle_ns == 0 && peak_mbps == 0,
          "R10 values", int'(cycle_ns) + int'(words_left), 0);
      rst_n = 1'b1;

      dreq = 1'b1;
      go(4, 100, 3);                               // R1 slow mode
      check_cfg(480, 0, 4, "R1 R2 R3 mw0");
      wait_idle();
      chk(hi_cnt == 12, "R4 type A active cycles", hi_cnt, 12);
      chk(done && !residue_nz && words_left == 0, "R6 end", {done, residue_nz}, 2);

      go(6, 300, 4);                               // R1 raised by drive
      check_cfg(300, 1, 6, "R1 R2 R3 mw2");
      wait_idle();
      chk(hi_cnt == 12, "R4 type B active cycles", hi_cnt, 12);

      go(5, 200, 2);                               // drive below floor
      check_cfg(250, 2, 8, "R1 R2 R3 mw1");
      wait_idle();
      chk(hi_cnt == 4, "R4 type C active cycles", hi_cnt, 4);

      go(0, 900, 1);                               // R1 drive ignored
      check_cfg(480, 0, 4, "R1 sw0");
      wait_idle();

      go(6, 600, 1);                               // R2 fallback to A
      check_cfg(600, 0, 3, "R2 fallback");
      wait_idle();

      dreq = 1'b0;                                 // R5 wait for request
      go(5, 200, 2);
      repeat (10) @(negedge clk);
      chk(!strobe && busy && words_left == 2, "R5 held without dreq", words_left, 2);
      dreq = 1'b1;
      wait_idle();
      chk(hi_cnt == 4 && words_left == 0, "R5 resumes", hi_cnt, 4);

      go(6, 300, 0);                               // R7 zero count
      chk(done && !busy && !residue_nz && hi_cnt == 0, "R7 zero count", {done, busy}, 2);

      go(0, 0, 5);                                 // R8 abort while active
      for (int i = 0; i < 50 && !strobe; i++) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      wait_idle();
      chk(words_left == 4 && residue_nz && done, "R8 abort active", words_left, 4);

      dreq = 1'b0;                                 // R8 abort while waiting
      go(0, 0, 3);
      repeat (3) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(!busy && done && residue_nz && words_left == 3, "R8 abort waiting", words_left, 3);

      dreq = 1'b1;                                 // R9 start while busy
      go(6, 300, 6);
      repeat (5) @(negedge clk);
      go(0, 0, 1);
      chk(timing_type == 1 && cycle_ns == 300, "R9 start ignored", cycle_ns, 300);
      wait_idle();
      chk(words_left == 0 && !residue_nz, "R9 run completes", words_left, 0);
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      @(negedge clk);
      chk(done && !busy && !residue_nz && words_left == 0, "R9 idle abort ignored", {done, busy}, 2);

      dreq_rand = 1;                               // random sweep, model-checked
      for (int n = 0; n < 40; n++) begin
         go(int'($urandom % 8), int'($urandom % 700), int'($urandom % 12));
         if ($urandom % 3 == 0) begin
            repeat (int'($urandom % 30)) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
         end
         wait_idle();
         @(negedge clk);
      end
      dreq_rand = 0;

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule